// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block sits between the internal operation timer of a flash memory model and its read data path. When a byte program or a full erase is launched, it counts the operation's duration in clock cycles, drives an open-drain busy line low for that time, and changes what a host read returns. While the operation runs, a read does not return array contents. It returns a status byte built from two bits:

- A polling bit that carries the inverse of the most significant bit of the byte being programmed.
- A toggle bit that flips on every read.

When the operation ends, reads return array data again.

The program and erase durations are parameters given in clock cycles. An active-low reset stops any running operation without reporting completion and forces the read outputs off. Reads are enabled only while both chip enable and output enable are low.

Top module: `flash_status_unit`

## Requirements
- R1: While `rst_n` is low, `rd_oe`, `busy_pull` and `op_done` are 0 and `rd_data` is all zeros.
- R2: A launch strobe taken while idle holds `busy_pull` at 1 for exactly PROG_CYCLES cycles (`start_prog`) or ERASE_CYCLES cycles (`start_erase`). `op_done` is 1 only in the last of those cycles. If both strobes are high together, the program wins.
- R3: During a program, an enabled read whose `rd_addr` equals the latched program address returns bit 7 equal to the inverse of bit 7 of the latched program data.
- R4: During any operation, bit 6 of an enabled read is 0 on the first read after launch. Each enabled read strobe (`rd_stb` with the read enabled) inverts bit 6 for the next read.
- R5: During an erase, bit 7 of every enabled read is 0.
- R6: When no operation runs and the read is enabled, `rd_data` equals `array_data`.
- R7: When `ce_n` or `oe_n` is high, `rd_oe` is 0 and `rd_data` is zero. A read strobe given in that state does not change bit 6.
- R8: Taking `rst_n` low during an operation ends it with no `op_done` pulse. After release, reads return array data.
- R9: A launch strobe given while busy is ignored. The running operation neither restarts nor lengthens, and the latched address and data are kept.
- R10: During an operation, bits 5..0 of an enabled read are 0. During a program, a read at any address other than the latched one returns bit 7 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; halts any operation |
| start_prog | input | 1 | One-cycle launch strobe for a byte program |
| start_erase | input | 1 | One-cycle launch strobe for a full erase |
| prog_addr | input | AW | Address of the byte being programmed, latched at launch |
| prog_data | input | DW | Data being programmed, latched at launch |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_stb | input | 1 | One-cycle marker of a host read access |
| rd_addr | input | AW | Read address |
| array_data | input | DW | Data read from the storage array at `rd_addr` |
| rd_data | output | DW | Data presented to the output buffer |
| rd_oe | output | 1 | Enable for the external tristate buffer |
| busy_pull | output | 1 | Open-drain pull-down enable; 1 pulls the ready/busy line low |
| op_done | output | 1 | High in the final cycle of an operation that completes |

## Verification
The main function is exercised with several kinds of input:

- Repeated polls at the programmed address, which show the inverted polling bit and the alternation of the toggle bit.
- Polls at other addresses, which separate the address match from plain status substitution.
- Two program data values with opposite top bits, which catch a polling bit that is stuck or not inverted.
- An erase, which separates the erase status from the program status.
- Read strobes with an output enable high, which show that a disabled read does not advance the toggle.
- Launch strobes given while busy, and a reset in the middle of an operation, which test the duration rules and the rule that a halted operation never reports completion.

A behavioural reference model compares every output on every cycle.

// File: rtl/flash_status_unit.sv
module flash_status_unit #(
  parameter int AW           = 20,
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 2500,
  parameter int ERASE_CYCLES = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          busy_pull,
  output logic          op_done
);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q, erase_q, tog_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          rd_go, last, launch;
  logic [DW-1:0] stat;

  assign rd_oe  = rst_n & ~ce_n & ~oe_n;
  assign rd_go  = rd_stb & rd_oe;
  assign last   = busy_q & (cnt_q == '0);
  assign launch = ~busy_q & (start_prog | start_erase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      tog_q   <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      erase_q <= ~start_prog;
      tog_q   <= 1'b0;
      cnt_q   <= start_prog ? CW'(PROG_CYCLES - 1) : CW'(ERASE_CYCLES - 1);
      if (start_prog) begin
        addr_q <= prog_addr;
        data_q <= prog_data;
      end
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q - 1'b1;
      if (rd_go) tog_q <= ~tog_q;
    end
  end

  always_comb begin
    stat    = '0;
    stat[6] = tog_q;
    stat[7] = ~erase_q & (rd_addr == addr_q) & ~data_q[7];
  end

  assign rd_data   = !rd_oe ? '0 : (busy_q ? stat : array_data);
  assign busy_pull = busy_q;
  assign op_done   = last;

  a_r2_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !busy_pull);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_pull && !op_done && (start_prog || start_erase)) |=> busy_pull && $stable(addr_q) && $stable(data_q));
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (!rd_oe && rd_data == '0));
  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_pull && rd_stb && rd_oe) |=> (tog_q != $past(tog_q)));
  a_r6_true_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_pull && rd_oe) |-> (rd_data == array_data));
  a_r3_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_pull && !erase_q && rd_oe && rd_addr == addr_q) |-> (rd_data[7] == ~data_q[7]));
  a_r5_erase_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_pull && erase_q && rd_oe) |-> !rd_data[7]);
endmodule

// File: tb/flash_status_unit_tb.sv
module flash_status_unit_tb;
  localparam int PC = 12;
  localparam int EC = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_prog = 0, start_erase = 0, ce_n = 1, oe_n = 1, rd_stb = 0;
  logic [19:0] prog_addr = '0, rd_addr = '0;
  logic [7:0]  prog_data = '0, array_data;
  logic [7:0]  rd_data;
  logic        rd_oe, busy_pull, op_done;

  always #2 clk = ~clk;
  assign array_data = rd_addr[7:0] ^ 8'h5A;

  flash_status_unit #(.AW(20), .DW(8), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .prog_addr(prog_addr), .prog_data(prog_data), .ce_n(ce_n), .oe_n(oe_n),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .array_data(array_data),
    .rd_data(rd_data), .rd_oe(rd_oe), .busy_pull(busy_pull), .op_done(op_done));

  int errors = 0, checks = 0, done_cnt = 0;
  int left = 0;
  bit m_erase = 0, m_tog = 0, finished = 0;
  logic [19:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  string tag = "R1";

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic step();
    bit e_oe;
    logic [7:0] e_data;
    if (!rst_n) begin left = 0; m_erase = 0; m_tog = 0; m_addr = '0; m_data = '0; end
    #1;
    e_oe = rst_n && !ce_n && !oe_n;
    if (!e_oe) e_data = 8'h00;
    else if (left > 0) e_data = {(!m_erase && rd_addr == m_addr) ? ~m_data[7] : 1'b0, m_tog, 6'b0};
    else e_data = array_data;
    chk(tag, "rd_data", int'(rd_data), int'(e_data));
    chk(tag, "rd_oe", int'(rd_oe), int'(e_oe));
    chk("R2", "busy_pull", int'(busy_pull), int'(left > 0));
    chk("R2", "op_done", int'(op_done), int'(left == 1));
    if (op_done) done_cnt++;
    @(posedge clk);
    if (rst_n) begin
      if (left > 0) begin
        if (rd_stb && e_oe) m_tog = ~m_tog;
        left--;
      end else if (start_prog || start_erase) begin
        left = start_prog ? PC : EC;
        m_erase = !start_prog;
        m_tog = 0;
        if (start_prog) begin m_addr = prog_addr; m_data = prog_data; end
      end
    end
    @(negedge clk);
    start_prog = 0; start_erase = 0; rd_stb = 0;
  endtask

  task automatic rd(logic [19:0] a, bit c, bit o);
    rd_addr = a; ce_n = c; oe_n = o; rd_stb = 1;
    step();
  endtask

  task automatic launch(bit p, bit e, logic [19:0] a, logic [7:0] d);
    start_prog = p; start_erase = e; prog_addr = a; prog_data = d;
    step();
  endtask

  initial begin
    @(negedge clk);
    tag = "R1";
    ce_n = 0; oe_n = 0;
    repeat (3) step();
    rst_n = 1;
    tag = "R6";
    for (int i = 0; i < 4; i++) rd(20'h00100 + 20'(i), 0, 0);
    tag = "R7";
    rd(20'h00033, 1, 0);
    rd(20'h00033, 0, 1);

    tag = "R3";
    done_cnt = 0;
    launch(1, 0, 20'h12345, 8'h3C);
    for (int i = 0; i < 3; i++) rd(20'h12345, 0, 0);
    tag = "R10";
    rd(20'h00045, 0, 0);
    tag = "R7";
    rd(20'h12345, 0, 1);
    rd(20'h12345, 1, 1);
    tag = "R9";
    launch(0, 1, 20'h0, 8'h0);
    launch(1, 0, 20'h00AAA, 8'hFF);
    tag = "R4";
    rd(20'h12345, 0, 0);
    rd(20'h12345, 0, 0);
    while (left > 0) rd(20'h12345, 0, 0);
    chk("R2", "done pulses after program", done_cnt, 1);
    tag = "R6";
    rd(20'h12345, 0, 0);
    rd(20'h00077, 0, 0);

    tag = "R3";
    launch(1, 1, 20'h00200, 8'h80);
    while (left > 0) rd(20'h00200, 0, 0);

    tag = "R5";
    done_cnt = 0;
    launch(0, 1, 20'h0, 8'h0);
    for (int i = 0; i < 5; i++) rd(20'h00000 + 20'(i), 0, 0);
    while (left > 0) step();
    chk("R2", "done pulses after erase", done_cnt, 1);
    tag = "R6";
    rd(20'h00005, 0, 0);

    tag = "R8";
    done_cnt = 0;
    launch(1, 0, 20'h00300, 8'h11);
    rd(20'h00300, 0, 0);
    rd(20'h00300, 0, 0);
    rst_n = 0;
    step(); step();
    rst_n = 1;
    repeat (PC + 2) rd(20'h00300, 0, 0);
    chk("R8", "done pulses after halted program", done_cnt, 0);
    chk("R8", "busy after halt", int'(busy_pull), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule